// File: doc/BRIEF.md
# Clock Control Register Pair with Switching Interlocks

This block holds the software-visible state of a clock-and-reset controller. It has two byte registers on a small synchronous register bus: a control register and a fast-clock prescaler register. The control register selects the clock sources, powers the PLL down and enables two auxiliary clocks. The prescaler register holds the fast divisor and the PLL mode. Hardware interlocks reject writes that would leave the system without a working clock. Leaving the main clock is refused while the PLL is off or not yet stable. PLL power-down is refused unless the main clock stays selected. The prescaler settings are frozen while the PLL drives the system.

A power-on flag is set by a detect pulse from outside and can only be cleared by software. The fast divisor drives a model prescaler: a counter that produces a one-cycle enable pulse every divisor plus one cycles. The real clock multiplexing, the PLL and the oscillators sit outside this block. Reads are combinational from the address. Writes take effect at the clock edge on which `bus_we` is high.

Top module: `clk_ctl_regs`

## Requirements
- R1: After reset, the control register (offset 0) reads 0x26 and the prescaler register (offset 2) reads 0x4F. `pll_pwrdn` and `sysclk_main` are 1. `slowclk_osc`, `aux1_run` and `aux2_run` are 0. `pll_mode` is 4 and `fast_div` is 15.
- R2: Control bit 0 is the slow clock select. It takes any written value and drives `slowclk_osc`, where 1 means the low-frequency oscillator.
- R3: Control bit 1 is the fast clock select, where 1 means main clock and 0 means PLL, and it drives `sysclk_main`. Writing 1 always takes effect. Writing 0 is ignored while the stored PLL power-down bit is 1 or `pll_stable` is 0.
- R4: Control bit 2 is PLL power-down and drives `pll_pwrdn`. Writing 0 always takes effect. Writing 1 takes effect only if the fast clock select is 1 both before the write and after it.
- R5: Control bits 3 and 4 are the auxiliary enables. `aux1_run` and `aux2_run` are 1 in the cycle after their enable bit and `main_stable` are both 1, and 0 otherwise.
- R6: Control bit 5 is the power-on flag. Writing 0 clears it and writing 1 leaves it unchanged. A `por_detect` pulse sets it, and it wins over a software clear in the same cycle.
- R7: In the prescaler register, bits 3:0 are the divisor (`fast_div`) and bits 6:4 are the PLL mode (`pll_mode`). Bit 7 reads 0. Writes to this register are ignored while `sysclk_main` is 0.
- R8: Control bits 7:6 read 0 and ignore writes. Addresses 1 and 3 read 0, and writes to them change nothing.
- R9: `fast_tick` is a one-cycle pulse repeating every `fast_div`+1 cycles. A divisor of 0 keeps it high every cycle. A new divisor applies from the next counter wrap.
- R10: `pll_pwrdn` = 1 with `sysclk_main` = 0 never occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pll_stable | input | 1 | PLL output has locked |
| main_stable | input | 1 | Main clock is stable |
| por_detect | input | 1 | Power-on detected pulse |
| pll_pwrdn | output | 1 | PLL power-down request |
| sysclk_main | output | 1 | 1: system prescaler from main clock, 0: from PLL |
| slowclk_osc | output | 1 | 1: slow clock from oscillator, 0: from prescaled main clock |
| aux1_run | output | 1 | Auxiliary clock 1 running |
| aux2_run | output | 1 | Auxiliary clock 2 running |
| pll_mode | output | MODE_W | PLL mode field |
| fast_div | output | DIV_W | Fast divisor field |
| fast_tick | output | 1 | Prescaler enable pulse |

## Verification
The bench goes after each interlock on both sides of its condition. It tries to switch to the PLL with the PLL off, then with it unstable, then with both satisfied. It tries to power the PLL down while the PLL is selected, and in a single write that also reselects the main clock. A design that checks only one condition, or that looks at the new select value instead of the held one, leaves a dead PLL selected or stops the PLL that is in use. The power-on flag is driven with a write of 1 and with a clear in the same cycle as a detect pulse; a plain read/write bit would lose the detect. The prescaler is written while locked and while unlocked, and the tick period is measured before and after a divisor change, including divisor 0. An off-by-one counter or a lock taken from the wrong bit shows up as a wrong period.

// File: rtl/clk_ctl_pkg.sv
package clk_ctl_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CTRL_USED = 6;

  // control register layout, msb first (bit 5 .. bit 0)
  typedef struct packed {
    logic por;
    logic aux2;
    logic aux1;
    logic pwrdn;
    logic fast;
    logic slow;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{por: 1'b1, aux2: 1'b0, aux1: 1'b0,
                                 pwrdn: 1'b1, fast: 1'b1, slow: 1'b0};
endpackage

// File: rtl/clk_ctl_ctrl_reg.sv
module clk_ctl_ctrl_reg
  import clk_ctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  ctrl_t wr_val,
  input  logic  pll_stable,
  input  logic  por_detect,
  output ctrl_t state
);
  ctrl_t nxt;

  always_comb begin
    nxt = state;
    if (wr_en) begin
      nxt.slow  = wr_val.slow;
      nxt.aux1  = wr_val.aux1;
      nxt.aux2  = wr_val.aux2;
      // leaving the main clock needs a powered, locked PLL
      nxt.fast  = wr_val.fast | (state.fast & (state.pwrdn | ~pll_stable));
      // power-down only while main clock is held and stays held
      nxt.pwrdn = wr_val.pwrdn ? (state.pwrdn | (state.fast & nxt.fast)) : 1'b0;
      // flag is clear-only from software
      nxt.por   = state.por & wr_val.por;
    end
    if (por_detect) nxt.por = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= CTRL_RST;
    else     state <= nxt;
  end
endmodule

// File: rtl/clk_ctl_prsc_reg.sv
module clk_ctl_prsc_reg #(
  parameter int unsigned DIV_W    = 4,
  parameter int unsigned MODE_W   = 3,
  parameter int unsigned RST_DIV  = 15,
  parameter int unsigned RST_MODE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              unlocked,
  input  logic [DIV_W-1:0]  wr_div,
  input  logic [MODE_W-1:0] wr_mode,
  output logic [DIV_W-1:0]  div,
  output logic [MODE_W-1:0] mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      div  <= DIV_W'(RST_DIV);
      mode <= MODE_W'(RST_MODE);
    end else if (wr_en && unlocked) begin
      div  <= wr_div;
      mode <= wr_mode;
    end
  end
endmodule

// File: rtl/clk_ctl_tick_div.sv
module clk_ctl_tick_div #(
  parameter int unsigned DIV_W   = 4,
  parameter int unsigned RST_DIV = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] active;
  logic             wrap;

  assign wrap = (cnt == active);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      active <= DIV_W'(RST_DIV);
      tick   <= 1'b0;
    end else begin
      tick <= wrap;
      if (wrap) begin
        cnt    <= '0;
        active <= div;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_ctl_regs.sv
module clk_ctl_regs
  import clk_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned CTRL_OFS = 0,
  parameter int unsigned PRSC_OFS = 2,
  parameter int unsigned DIV_W    = 4,
  parameter int unsigned MODE_W   = 3,
  parameter int unsigned RST_DIV  = 15,
  parameter int unsigned RST_MODE = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              pll_stable,
  input  logic              main_stable,
  input  logic              por_detect,
  output logic              pll_pwrdn,
  output logic              sysclk_main,
  output logic              slowclk_osc,
  output logic              aux1_run,
  output logic              aux2_run,
  output logic [MODE_W-1:0] pll_mode,
  output logic [DIV_W-1:0]  fast_div,
  output logic              fast_tick
);
  localparam int unsigned PRSC_USED = DIV_W + MODE_W;

  logic  sel_ctrl, sel_prsc;
  ctrl_t ctrl;
  logic  unused_wbits;

  assign sel_ctrl     = (bus_addr == ADDR_W'(CTRL_OFS));
  assign sel_prsc     = (bus_addr == ADDR_W'(PRSC_OFS));
  assign unused_wbits = &{1'b0, bus_wdata[BYTE_W-1:CTRL_USED], bus_wdata[BYTE_W-1:PRSC_USED]};

  clk_ctl_ctrl_reg u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (bus_we && sel_ctrl),
    .wr_val     (ctrl_t'(bus_wdata[CTRL_USED-1:0])),
    .pll_stable (pll_stable),
    .por_detect (por_detect),
    .state      (ctrl)
  );

  clk_ctl_prsc_reg #(
    .DIV_W(DIV_W), .MODE_W(MODE_W), .RST_DIV(RST_DIV), .RST_MODE(RST_MODE)
  ) u_prsc (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (bus_we && sel_prsc),
    .unlocked (ctrl.fast),
    .wr_div   (bus_wdata[DIV_W-1:0]),
    .wr_mode  (bus_wdata[PRSC_USED-1:DIV_W]),
    .div      (fast_div),
    .mode     (pll_mode)
  );

  clk_ctl_tick_div #(.DIV_W(DIV_W), .RST_DIV(RST_DIV)) u_div (
    .clk  (clk),
    .rst  (rst),
    .div  (fast_div),
    .tick (fast_tick)
  );

  assign pll_pwrdn   = ctrl.pwrdn;
  assign sysclk_main = ctrl.fast;
  assign slowclk_osc = ctrl.slow;

  always_ff @(posedge clk) begin
    if (rst) begin
      aux1_run <= 1'b0;
      aux2_run <= 1'b0;
    end else begin
      aux1_run <= ctrl.aux1 & main_stable;
      aux2_run <= ctrl.aux2 & main_stable;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl)      bus_rdata = BYTE_W'(ctrl);
    else if (sel_prsc) bus_rdata = BYTE_W'({pll_mode, fast_div});
  end
endmodule

// File: rtl/clk_ctl_regs_chk.sv
module clk_ctl_regs_chk #(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned CTRL_OFS = 0,
  parameter int unsigned DIV_W    = 4,
  parameter int unsigned MODE_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [7:0]        bus_rdata,
  input logic              pll_stable,
  input logic              main_stable,
  input logic              por_detect,
  input logic              pll_pwrdn,
  input logic              sysclk_main,
  input logic              aux1_run,
  input logic              aux2_run,
  input logic [MODE_W-1:0] pll_mode,
  input logic [DIV_W-1:0]  fast_div
);
  // R10
  pll_off_unused_chk: assert property (@(posedge clk) disable iff (rst)
    !(pll_pwrdn && !sysclk_main));

  // R3
  pll_switch_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sysclk_main) |-> ($past(bus_we) && $past(pll_stable) && !$past(pll_pwrdn)));

  // R4
  pwrdn_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_pwrdn) |-> ($past(sysclk_main) && sysclk_main));

  // R5
  aux1_needs_main_chk: assert property (@(posedge clk) disable iff (rst)
    aux1_run |-> $past(main_stable));

  // R5
  aux2_needs_main_chk: assert property (@(posedge clk) disable iff (rst)
    aux2_run |-> $past(main_stable));

  // R6
  por_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_addr == ADDR_W'(CTRL_OFS)) && $past(por_detect)) |-> bus_rdata[5]);

  // R7
  prsc_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sysclk_main) |-> ($stable(fast_div) && $stable(pll_mode)));

  // R8
  ctrl_reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(CTRL_OFS)) |-> (bus_rdata[7:6] == 2'b00));
endmodule

bind clk_ctl_regs clk_ctl_regs_chk #(
  .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .DIV_W(DIV_W), .MODE_W(MODE_W)
) u_chk (.*);

// File: tb/clk_ctl_regs_bench.sv
`timescale 1ns/1ps
module clk_ctl_regs_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       pll_stable = 1'b0;
  logic       main_stable = 1'b0;
  logic       por_detect = 1'b0;
  logic       pll_pwrdn, sysclk_main, slowclk_osc, aux1_run, aux2_run, fast_tick;
  logic [2:0] pll_mode;
  logic [3:0] fast_div;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  clk_ctl_regs u_clk_ctl_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pll_stable(pll_stable),
    .main_stable(main_stable), .por_detect(por_detect), .pll_pwrdn(pll_pwrdn),
    .sysclk_main(sysclk_main), .slowclk_osc(slowclk_osc), .aux1_run(aux1_run),
    .aux2_run(aux2_run), .pll_mode(pll_mode), .fast_div(fast_div),
    .fast_tick(fast_tick)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic period(output int p);
    int n;
    while (!fast_tick) @(negedge clk);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!fast_tick && n < 100);
    p = n;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    int p;
    rd(2'd0, v); chk("R1 ctrl reset", v, 8'h26);
    rd(2'd2, v); chk("R1 prsc reset", v, 8'h4F);
    chk("R1 outputs", {pll_pwrdn, sysclk_main, slowclk_osc, aux1_run, aux2_run}, 5'b11000);
    chk("R1 mode/div", {pll_mode, fast_div}, 7'h4F);
    period(p); chk("R9 default period", p, 16);
  endtask

  task automatic t_slow();
    logic [7:0] v;
    wr(2'd0, 8'h27);
    chk("R2 slow set", slowclk_osc, 1);
    rd(2'd0, v); chk("R2 readback", v, 8'h27);
    wr(2'd0, 8'h26);
    chk("R2 slow clear", slowclk_osc, 0);
  endtask

  task automatic t_interlock();
    logic [7:0] v;
    wr(2'd0, 8'h24);                      // select PLL while PLL off
    rd(2'd0, v); chk("R3 pll off blocks", v, 8'h26);
    wr(2'd0, 8'h22);                      // power PLL up
    rd(2'd0, v); chk("R4 clear pwrdn", v, 8'h22);
    wr(2'd0, 8'h20);                      // PLL not stable yet
    chk("R3 unstable blocks", sysclk_main, 1);
    pll_stable = 1'b1;
    wr(2'd0, 8'h20);
    chk("R3 switch to pll", sysclk_main, 0);
    wr(2'd2, 8'h23);                      // locked prescaler
    rd(2'd2, v); chk("R7 write locked", v, 8'h4F);
    wr(2'd0, 8'h24);                      // power down while on PLL
    rd(2'd0, v); chk("R4 pwrdn blocked", v, 8'h20);
    wr(2'd0, 8'h26);                      // reselect main and power down together
    rd(2'd0, v); chk("R4 same-write blocked", v, 8'h22);
    chk("R10 no pwrdn on pll", pll_pwrdn, 0);
    wr(2'd0, 8'h26);
    chk("R4 pwrdn accepted", pll_pwrdn, 1);
  endtask

  task automatic t_por();
    logic [7:0] v;
    wr(2'd0, 8'h06);
    rd(2'd0, v); chk("R6 clear", v, 8'h06);
    wr(2'd0, 8'h26);
    rd(2'd0, v); chk("R6 write one ignored", v, 8'h06);
    @(negedge clk); por_detect = 1'b1;
    @(negedge clk); por_detect = 1'b0;
    rd(2'd0, v); chk("R6 detect sets", v, 8'h26);
    @(negedge clk);
    bus_addr = 2'd0; bus_wdata = 8'h06; bus_we = 1'b1; por_detect = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; por_detect = 1'b0;
    rd(2'd0, v); chk("R6 detect beats clear", v, 8'h26);
  endtask

  task automatic t_aux();
    main_stable = 1'b0;
    wr(2'd0, 8'h2E);
    @(negedge clk);
    chk("R5 aux1 main unstable", aux1_run, 0);
    main_stable = 1'b1;
    @(negedge clk);
    chk("R5 aux1/aux2 run", {aux1_run, aux2_run}, 2'b10);
    wr(2'd0, 8'h3E);
    @(negedge clk);
    chk("R5 both run", {aux1_run, aux2_run}, 2'b11);
    main_stable = 1'b0;
    @(negedge clk);
    chk("R5 main lost", {aux1_run, aux2_run}, 2'b00);
    wr(2'd0, 8'h26);
  endtask

  task automatic t_prsc();
    logic [7:0] v;
    int p;
    wr(2'd2, 8'hC3);
    rd(2'd2, v); chk("R7 write and bit7", v, 8'h43);
    chk("R7 fields", {pll_mode, fast_div}, 7'h43);
    period(p); period(p); period(p);
    chk("R9 period div3", p, 4);
    wr(2'd2, 8'h50);
    chk("R7 mode5 div0", {pll_mode, fast_div}, 7'h50);
    period(p); period(p); period(p);
    chk("R9 period div0", p, 1);
    wr(2'd2, 8'h4F);
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    wr(2'd0, 8'hE6);
    rd(2'd0, v); chk("R8 reserved bits", v, 8'h26);
    rd(2'd1, v); chk("R8 addr1 reads 0", v, 0);
    rd(2'd3, v); chk("R8 addr3 reads 0", v, 0);
    wr(2'd1, 8'hFF);
    wr(2'd3, 8'h00);
    rd(2'd0, v); chk("R8 ctrl untouched", v, 8'h26);
    rd(2'd2, v); chk("R8 prsc untouched", v, 8'h4F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_slow();
    t_interlock();
    t_por();
    t_aux();
    t_prsc();
    t_reserved();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule